// File: doc/BRIEF.md
# Deinterleaver Address Generator for Three Modulation Orders

This block produces the read-address sequence of a two-step block deinterleaver, one address per enabled cycle. The block size in coded bits (N) and the column count d (16 or 12) are set at run time. The modulation order is also set at run time and fixes the group size s: 1 for QPSK, 2 for 16-QAM and 3 for 64-QAM. A surrounding memory controller latches a configuration with a start pulse. It then holds the enable high whenever it can accept an address and reads its bit store at each address flagged valid. The block raises an end flag on the last address of the block.

For received index j, the address equals k = d·m − (N−1)·⌊d·m/N⌋, where m = s·⌊j/s⌋ + (j + ⌊d·j/N⌋) mod s. The block builds this with no divider in the address path. A fast counter steps through the positions within a segment of length N/d. A slow counter selects the segment. Two small modulo-s counters supply the in-group rotation. The address is then d times the rotated fast position plus the slow count. The multiply by d is done with shifts and one add. The same datapath serves all three modulation orders, and the rotation term reduces to zero when s = 1.

Top module: `deint_addr_gen`

## Requirements
- R1: Out of reset `addr_vld` and `blk_end` are 0, and no address is issued until a start pulse has latched a valid configuration.
- R2: After a start with a valid configuration, the n-th valid address (n counted from 0) equals k(n) from the formula above. `mod_sel` encodes s as 0→1, 1→2, 2→3, and `cols12` encodes d as 0→16, 1→12.
- R3: Exactly N valid addresses are issued per block, and each one is below N.
- R4: `blk_end` is high on the N-th valid address and on no other address. After it, `addr_vld` stays low until the next start.
- R5: While `en` is low, `addr_vld` is low and the sequence position is held. Clearing `en` inserts gaps in the sequence but does not change it.
- R6: A configuration is rejected when N is 0, when N is not a multiple of d·s, or when `mod_sel` is 3. A rejected configuration never raises `addr_vld`.
- R7: In the cycle `start` is high, `addr_vld` is low. A start given in the middle of a block abandons that block, and the next valid address is the first address (0) of the new configuration.
- R8: Configuration inputs are sampled only at start. Changing them during a block has no effect on the addresses issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Latch configuration and restart the sequence |
| en | input | 1 | Permission to issue an address this cycle |
| mod_sel | input | 2 | Modulation: 0 QPSK, 1 16-QAM, 2 64-QAM, 3 rejected |
| cols12 | input | 1 | Column count: 0 for 16, 1 for 12 |
| ncbps | input | AW | Block size N in coded bits |
| addr | output | AW | Deinterleaved read address |
| addr_vld | output | 1 | Address valid this cycle |
| blk_end | output | 1 | Last address of the block |

## Verification
The assertions assume that `start` comes only from the controller and that the latched N stays constant between starts, because the checker bounds each address by that latched value. The stimulus draws block sizes as random multiples of d·s within the address width, along with the smallest legal multiple. It applies random enable patterns, and it changes the configuration inputs only at start, except in the one test that checks they are ignored mid-block. Rejected settings are driven in directed cases only, so every address run from a random case begins from an accepted configuration.

// File: rtl/deint_addr_gen.sv
module deint_addr_gen #(
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          en,
  input  logic [1:0]    mod_sel,
  input  logic          cols12,
  input  logic [AW-1:0] ncbps,
  output logic [AW-1:0] addr,
  output logic          addr_vld,
  output logic          blk_end
);

  logic          act;
  logic [AW-1:0] cfg_n;
  logic          cfg_d12;
  logic [1:0]    cfg_s;
  logic [AW-1:0] fpos, fpos_d;
  logic [3:0]    seg;
  logic [1:0]    sub, rot;

  logic [1:0]    in_s;
  logic          in_ok;
  logic [AW-1:0] d_val;
  logic          fast_last, seg_last, fire;
  logic [2:0]    rsum;
  logic [1:0]    rmod;
  logic [AW-1:0] fpos_r;

  always_comb begin
    case (mod_sel)
      2'd0:    in_s = 2'd1;
      2'd1:    in_s = 2'd2;
      2'd2:    in_s = 2'd3;
      default: in_s = 2'd0;
    endcase
  end

  always_comb begin
    case ({cols12, mod_sel})
      3'b000:  in_ok = (ncbps % AW'(16)) == '0;
      3'b001:  in_ok = (ncbps % AW'(32)) == '0;
      3'b010:  in_ok = (ncbps % AW'(48)) == '0;
      3'b100:  in_ok = (ncbps % AW'(12)) == '0;
      3'b101:  in_ok = (ncbps % AW'(24)) == '0;
      3'b110:  in_ok = (ncbps % AW'(36)) == '0;
      default: in_ok = 1'b0;
    endcase
  end

  assign d_val     = cfg_d12 ? AW'(12) : AW'(16);
  assign fast_last = ({1'b0, fpos_d} + {1'b0, d_val}) == {1'b0, cfg_n};
  assign seg_last  = seg == (cfg_d12 ? 4'd11 : 4'd15);
  assign fire      = act & en & ~start;

  assign rsum   = {1'b0, sub} + {1'b0, rot};
  assign rmod   = (rsum >= {1'b0, cfg_s}) ? 2'(rsum - {1'b0, cfg_s}) : rsum[1:0];
  assign fpos_r = fpos - AW'(sub) + AW'(rmod);

  assign addr     = (cfg_d12 ? (fpos_r << 3) + (fpos_r << 2) : (fpos_r << 4)) + AW'(seg);
  assign addr_vld = fire;
  assign blk_end  = fire & fast_last & seg_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act     <= 1'b0;
      cfg_n   <= '0;
      cfg_d12 <= 1'b0;
      cfg_s   <= 2'd1;
      fpos    <= '0;
      fpos_d  <= '0;
      seg     <= '0;
      sub     <= '0;
      rot     <= '0;
    end else if (start) begin
      act     <= in_ok && (ncbps != '0);
      cfg_n   <= ncbps;
      cfg_d12 <= cols12;
      cfg_s   <= (in_s == 2'd0) ? 2'd1 : in_s;
      fpos    <= '0;
      fpos_d  <= '0;
      seg     <= '0;
      sub     <= '0;
      rot     <= '0;
    end else if (fire) begin
      if (fast_last) begin
        fpos   <= '0;
        fpos_d <= '0;
        sub    <= '0;
        if (seg_last) begin
          act <= 1'b0;
          seg <= '0;
          rot <= '0;
        end else begin
          seg <= seg + 4'd1;
          rot <= (rot == cfg_s - 2'd1) ? 2'd0 : rot + 2'd1;
        end
      end else begin
        fpos   <= fpos + AW'(1);
        fpos_d <= fpos_d + d_val;
        sub    <= (sub == cfg_s - 2'd1) ? 2'd0 : sub + 2'd1;
      end
    end
  end

endmodule

module deint_addr_gen_chk #(
  parameter int AW = 11
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          en,
  input logic [AW-1:0] addr,
  input logic          addr_vld,
  input logic          blk_end,
  input logic [AW-1:0] cfg_n
);

  // R4
  end_has_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blk_end |-> addr_vld);

  // R4
  quiet_after_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blk_end |=> !addr_vld);

  // R5
  stall_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !addr_vld);

  // R7
  start_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !addr_vld);

  // R7
  first_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(start) && addr_vld) |-> addr == '0);

  // R3
  addr_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_vld |-> addr < cfg_n);

endmodule

bind deint_addr_gen deint_addr_gen_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .en(en), .addr(addr),
  .addr_vld(addr_vld), .blk_end(blk_end), .cfg_n(cfg_n)
);

// File: tb/sim_deint_addr_gen.sv
module sim_deint_addr_gen;
  localparam int AW = 11;
  localparam time CLK_PERIOD = 10ns;
  localparam int WATCHDOG = 150000;

  logic clk = 0, rst_n = 0, start = 0, en = 0, cols12 = 0;
  logic [1:0] mod_sel = 0;
  logic [AW-1:0] ncbps = 0;
  logic [AW-1:0] addr;
  logic addr_vld, blk_end;

  int checks = 0, errors = 0, cycles = 0;
  bit done = 0;

  deint_addr_gen #(.AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .en(en), .mod_sel(mod_sel),
    .cols12(cols12), .ncbps(ncbps), .addr(addr), .addr_vld(addr_vld), .blk_end(blk_end)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int ref_k(int j, int n, int d, int s);
    int m;
    m = s * (j / s) + ((j + (d * j) / n) % s);
    return d * m - (n - 1) * ((d * m) / n);
  endfunction

  task automatic chk(bit ok, string req, int act_v, int exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act_v, exp_v);
    end
  endtask

  task automatic do_start(int ms, int c12, int n);
    @(negedge clk);
    start = 1; mod_sel = 2'(ms); cols12 = c12[0]; ncbps = AW'(n); en = 1;
    #1 chk(addr_vld == 0, "R7 vld low during start", int'(addr_vld), 0);
    @(negedge clk);
    start = 0;
  endtask

  // runs the block to completion; returns with one cycle after end checked
  task automatic run_block(int ms, int c12, int n, int en_pct, bit scramble);
    int d, s, j;
    d = c12 ? 12 : 16;
    s = ms + 1;
    j = 0;
    do_start(ms, c12, n);
    while (j < n) begin
      en = ($urandom_range(99) < en_pct);
      if (scramble) begin
        mod_sel = 2'($urandom_range(3)); cols12 = 1'($urandom_range(1));
        ncbps = AW'($urandom_range(2047));
      end
      #1;
      if (!en) chk(addr_vld == 0, "R5 stall", int'(addr_vld), 0);
      if (addr_vld) begin
        chk(int'(addr) == ref_k(j, n, d, s), scramble ? "R8 address" : "R2 address",
            int'(addr), ref_k(j, n, d, s));
        chk(blk_end == (j == n - 1), "R4 end flag", int'(blk_end), int'(j == n - 1));
        chk(int'(addr) < n, "R3 bound", int'(addr), n - 1);
        j++;
      end
      @(negedge clk);
    end
    en = 1;
    #1 chk(addr_vld == 0, "R3 count / R4 quiet after end", int'(addr_vld), 0);
    @(negedge clk);
    en = 0;
  endtask

  task automatic expect_silent(int ms, int c12, int n, string req);
    bit seen;
    seen = 0;
    do_start(ms, c12, n);
    en = 1;
    for (int i = 0; i < 30; i++) begin
      #1 if (addr_vld) seen = 1;
      @(negedge clk);
    end
    en = 0;
    chk(!seen, req, int'(seen), 0);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(addr_vld == 0 && blk_end == 0, "R1 reset outputs", int'(addr_vld), 0);
    rst_n = 1;
    en = 1;
    repeat (5) begin
      @(negedge clk);
      #1 chk(addr_vld == 0, "R1 idle before start", int'(addr_vld), 0);
    end
    en = 0;

    // directed: smallest legal block for each of the six settings
    for (int c = 0; c < 2; c++)
      for (int ms = 0; ms < 3; ms++)
        run_block(ms, c, (c ? 12 : 16) * (ms + 1), 100, 0);

    // R2 with common sizes
    run_block(0, 0, 192, 100, 0);
    run_block(1, 0, 384, 100, 0);
    run_block(2, 0, 576, 100, 0);
    run_block(2, 1, 1152, 70, 0);

    // random blocks, random enable density
    for (int t = 0; t < 24; t++) begin
      int ms, c, step, mult;
      ms = $urandom_range(2);
      c = $urandom_range(1);
      step = (c ? 12 : 16) * (ms + 1);
      mult = $urandom_range(1, 2047 / step);
      run_block(ms, c, step * mult, $urandom_range(30, 100), 0);
    end

    // R6 rejected configurations
    expect_silent(0, 0, 0, "R6 zero size");
    expect_silent(0, 0, 100, "R6 not multiple of 16");
    expect_silent(1, 0, 48, "R6 not multiple of 32");
    expect_silent(2, 1, 24, "R6 not multiple of 36");
    expect_silent(3, 0, 96, "R6 mod_sel 3");

    // R7 restart mid-block
    do_start(2, 0, 480);
    en = 1;
    repeat (7) @(negedge clk);
    en = 0;
    run_block(1, 1, 240, 100, 0);

    // R8 config inputs ignored mid-block
    run_block(1, 0, 640, 80, 1);

    done = 1;
  end

  initial begin
    while (!done && cycles < WATCHDOG) begin
      @(posedge clk);
      cycles++;
    end
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=%0d expected<%0d", cycles, WATCHDOG);
    end
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule